// File: doc/BRIEF.md
# Interlaced Field Capture Line Window

This block follows vertical video timing that arrives on two separate, free-running sync wires, one for horizontal and one for vertical. It does not decode timing codes carried in the video stream. Both wires are asynchronous to the block clock. Each one is resynchronised and reduced to a one-cycle leading-edge event. The block counts lines from the latest vertical leading edge. In interlaced mode it also keeps track of which field is in progress.

From the line count it drives two flags. The first, a capture-enable window, tells a downstream pixel writer which lines belong to active video. The second flag marks the vertical-blanking data region.

The window bounds depend on the mode. In interlaced operation each field has its own start/end pair. In progressive operation one frame-wide pair is used and the field pairs are ignored. The blanking-data flag starts at a programmed line count that applies to every field or frame. It stays raised until the active window opens.

Top module: `field_line_window`

## Requirements
- R1: Each sync input passes through a two-flop synchroniser and a leading-edge detector. A rising input changes `line_num` on the third clock edge after the input changes. Holding an input high produces no further events.
- R2: A vertical leading edge sets `line_num` to 0. It takes priority over a horizontal leading edge seen in the same cycle.
- R3: Each horizontal leading edge with no vertical edge in the same cycle adds one to `line_num`. At 4095 the count saturates and does not wrap.
- R4: `field_even` is 0 after reset. In interlaced mode (`prog_mode` = 0) it inverts on every vertical leading edge. While `prog_mode` is 1 it is held at 0.
- R5: In interlaced mode with `field_even` = 1, `line_capture` is 1 exactly when `even_first` <= `line_num` <= `even_last`. The last line included is `even_last`.
- R6: In interlaced mode with `field_even` = 0, `line_capture` is 1 exactly when `odd_first` <= `line_num` <= `odd_last`.
- R7: When `prog_mode` = 1, the window is `frame_first` <= `line_num` <= `frame_last`. Both field pairs have no effect on `line_capture`.
- R8: If the selected first line is greater than the selected last line, `line_capture` stays 0 for the whole field or frame.
- R9: `vbi_active` is 1 exactly when `line_num` >= `vbi_first` and `line_num` is below the selected first line. All line fields are 12 bits wide.
- R10: After reset `line_num` is 0, `field_even` is 0, and `line_capture` and `vbi_active` follow R5 to R9 for line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Asynchronous horizontal sync, active high |
| vsync_in | input | 1 | Asynchronous vertical sync, active high |
| prog_mode | input | 1 | 1 selects progressive (non-interlaced) timing |
| odd_first | input | 12 | First captured line of the odd field |
| odd_last | input | 12 | Last captured line of the odd field |
| even_first | input | 12 | First captured line of the even field |
| even_last | input | 12 | Last captured line of the even field |
| frame_first | input | 12 | First captured line in progressive mode |
| frame_last | input | 12 | Last captured line in progressive mode |
| vbi_first | input | 12 | Line count at which the blanking-data region begins |
| line_capture | output | 1 | Current line lies in the active capture window |
| vbi_active | output | 1 | Current line lies in the blanking-data region |
| line_num | output | 12 | Lines counted since the last vertical leading edge |
| field_even | output | 1 | 1 while the even field is in progress |

## Verification
The case hardest to reach from the ports is saturation. Getting there takes more than four thousand horizontal pulses with no vertical pulse in between, so the bench runs one long dedicated burst and then checks that further pulses leave the count at its maximum. Coincident sync edges also need care, because the two-flop path makes their timing hard to line up. Both wires are raised on the same drive cycle so that their edges arrive together. Random fields with small random bounds cover start-after-end cases and mode switches in both parities.

// File: rtl/flw_pkg.sv
package flw_pkg;
  parameter int unsigned FLW_LINE_W = 12;
  typedef logic [FLW_LINE_W-1:0] line_t;

  typedef struct packed {
    line_t first;
    line_t last;
  } span_t;

  function automatic line_t line_sat_inc(input line_t v);
    return (v == '1) ? v : line_t'(v + 1'b1);
  endfunction

  function automatic logic line_in_span(input line_t v, input span_t s);
    return (v >= s.first) && (v <= s.last);
  endfunction

  function automatic logic line_in_vbi(input line_t v, input line_t vbi, input line_t first);
    return (v >= vbi) && (v < first);
  endfunction
endpackage

// File: rtl/vline_sync_edge.sv
module vline_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[LAST];
    end
  end

  assign rise = chain[LAST] & ~prev;
endmodule

// File: rtl/vline_counter.sv
module vline_counter
  import flw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hs_rise,
  input  logic  vs_rise,
  input  logic  prog_mode,
  output line_t line_num,
  output logic  field_even
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_num   <= '0;
      field_even <= 1'b0;
    end else begin
      if (vs_rise)      line_num <= '0;
      else if (hs_rise) line_num <= line_sat_inc(line_num);

      if (prog_mode)    field_even <= 1'b0;
      else if (vs_rise) field_even <= ~field_even;
    end
  end
endmodule

// File: rtl/vline_window_sel.sv
module vline_window_sel
  import flw_pkg::*;
(
  input  line_t line_num,
  input  logic  field_even,
  input  logic  prog_mode,
  input  span_t odd_span,
  input  span_t even_span,
  input  span_t frame_span,
  input  line_t vbi_first,
  output span_t sel_span,
  output logic  line_capture,
  output logic  vbi_active
);
  always_comb begin
    if (prog_mode)       sel_span = frame_span;
    else if (field_even) sel_span = even_span;
    else                 sel_span = odd_span;
  end

  assign line_capture = line_in_span(line_num, sel_span);
  assign vbi_active   = line_in_vbi(line_num, vbi_first, sel_span.first);
endmodule

// File: rtl/field_line_window.sv
module field_line_window
  import flw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hsync_in,
  input  logic                  vsync_in,
  input  logic                  prog_mode,
  input  logic [FLW_LINE_W-1:0] odd_first,
  input  logic [FLW_LINE_W-1:0] odd_last,
  input  logic [FLW_LINE_W-1:0] even_first,
  input  logic [FLW_LINE_W-1:0] even_last,
  input  logic [FLW_LINE_W-1:0] frame_first,
  input  logic [FLW_LINE_W-1:0] frame_last,
  input  logic [FLW_LINE_W-1:0] vbi_first,
  output logic                  line_capture,
  output logic                  vbi_active,
  output logic [FLW_LINE_W-1:0] line_num,
  output logic                  field_even
);
  logic  hs_rise;
  logic  vs_rise;
  span_t sel_span;

  vline_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst_n(rst_n), .async_in(hsync_in), .rise(hs_rise));
  vline_sync_edge #(.STAGES(SYNC_STAGES)) u_vs (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .rise(vs_rise));

  vline_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .prog_mode(prog_mode), .line_num(line_num), .field_even(field_even));

  vline_window_sel u_win (
    .line_num(line_num), .field_even(field_even), .prog_mode(prog_mode),
    .odd_span('{first: odd_first, last: odd_last}),
    .even_span('{first: even_first, last: even_last}),
    .frame_span('{first: frame_first, last: frame_last}),
    .vbi_first(vbi_first), .sel_span(sel_span),
    .line_capture(line_capture), .vbi_active(vbi_active));
endmodule

// File: rtl/flw_checker.sv
module flw_checker
  import flw_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  hs_rise,
  input logic  vs_rise,
  input logic  prog_mode,
  input line_t line_num,
  input logic  field_even,
  input logic  line_capture,
  input logic  vbi_active
);
  a_r2_vsync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_num == '0));

  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vs_rise && line_num != '1) |=> (line_num == $past(line_num) + 1'b1));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vs_rise && line_num == '1) |=> (line_num == '1));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_rise && !vs_rise) |=> $stable(line_num));

  a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> !hs_rise);

  a_r4_parity_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && !prog_mode) |=> (field_even != $past(field_even)));

  a_r4_prog_even_low: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |=> !field_even);

  a_r9_flags_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_capture && vbi_active));
endmodule

bind field_line_window flw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
  .prog_mode(prog_mode), .line_num(line_num), .field_even(field_even),
  .line_capture(line_capture), .vbi_active(vbi_active));

// File: tb/field_line_window_bench.sv
module field_line_window_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, prog_mode = 1'b0;
  logic [11:0] odd_first = 0, odd_last = 0, even_first = 0, even_last = 0;
  logic [11:0] frame_first = 0, frame_last = 0, vbi_first = 0;
  logic line_capture, vbi_active, field_even;
  logic [11:0] line_num;

  int n_chk = 0;
  int n_fail = 0;
  int exp_line = 0;
  bit exp_even = 1'b0;

  always #2 clk = ~clk;

  field_line_window u_field_line_window (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .prog_mode(prog_mode), .odd_first(odd_first), .odd_last(odd_last),
    .even_first(even_first), .even_last(even_last),
    .frame_first(frame_first), .frame_last(frame_last), .vbi_first(vbi_first),
    .line_capture(line_capture), .vbi_active(vbi_active),
    .line_num(line_num), .field_even(field_even));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int pick_first();
    if (prog_mode) return frame_first;
    return exp_even ? even_first : odd_first;
  endfunction

  function automatic int pick_last();
    if (prog_mode) return frame_last;
    return exp_even ? even_last : odd_last;
  endfunction

  function automatic bit model_capture(input int ln);
    return !(ln < pick_first()) && !(ln > pick_last());
  endfunction

  function automatic bit model_vbi(input int ln);
    return (ln >= vbi_first) && (pick_first() > ln);
  endfunction

  task automatic check_all();
    string wreq;
    if (prog_mode) wreq = "R7";
    else if (pick_first() > pick_last()) wreq = "R8";
    else if (exp_even) wreq = "R5";
    else wreq = "R6";
    if (pick_first() > pick_last()) check(line_capture == 1'b0, "R8", line_capture, 0);
    check(line_num == exp_line, "R3 line", line_num, exp_line);
    check(field_even == exp_even, "R4 parity", field_even, exp_even);
    check(line_capture == model_capture(exp_line), wreq, line_capture, model_capture(exp_line));
    check(vbi_active == model_vbi(exp_line), "R9", vbi_active, model_vbi(exp_line));
  endtask

  task automatic hpulse();
    @(negedge clk) hsync_in = 1'b1;
    repeat (3) @(negedge clk);
    hsync_in = 1'b0;
    repeat (3) @(negedge clk);
    if (exp_line < 4095) exp_line++;
  endtask

  task automatic vpulse();
    @(negedge clk) vsync_in = 1'b1;
    repeat (3) @(negedge clk);
    vsync_in = 1'b0;
    repeat (3) @(negedge clk);
    exp_line = 0;
    exp_even = prog_mode ? 1'b0 : ~exp_even;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    odd_first = 3; odd_last = 6; even_first = 4; even_last = 8;
    frame_first = 2; frame_last = 9; vbi_first = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(line_num == 0, "R10 line", line_num, 0);
    check(field_even == 0, "R10 parity", field_even, 0);
    check(line_capture == 0, "R10 capture", line_capture, 0);
    check(vbi_active == 0, "R10 vbi", vbi_active, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 latency: unchanged after two edges, changed after third
    hsync_in = 1'b1;
    repeat (2) @(negedge clk);
    check(line_num == 0, "R1 latency early", line_num, 0);
    @(negedge clk);
    check(line_num == 1, "R1 latency", line_num, 1);
    repeat (10) @(negedge clk);
    check(line_num == 1, "R1 level hold", line_num, 1);
    hsync_in = 1'b0;
    repeat (4) @(negedge clk);
    exp_line = 1;
    check_all();
    hpulse(); check_all();
    check(vbi_active == 1, "R9 vbi at line2", vbi_active, 1);

    // R2 coincident edges: vertical wins
    hpulse(); hpulse();
    @(negedge clk) begin hsync_in = 1'b1; vsync_in = 1'b1; end
    repeat (3) @(negedge clk);
    hsync_in = 1'b0; vsync_in = 1'b0;
    repeat (3) @(negedge clk);
    exp_line = 0; exp_even = 1'b1;
    check(line_num == 0, "R2 priority", line_num, 0);
    check_all();

    // R7 field pairs ignored in progressive mode
    prog_mode = 1'b1; odd_first = 0; odd_last = 20; even_first = 0; even_last = 20;
    frame_first = 10; frame_last = 12; vbi_first = 30;
    vpulse();
    for (int i = 0; i < 5; i++) hpulse();
    check(line_capture == 0, "R7 ignore pairs", line_capture, 0);
    check_all();
    prog_mode = 1'b0;
    repeat (2) @(negedge clk);
    check(field_even == 0, "R4 after prog", field_even, 0);

    // random fields
    for (int f = 0; f < 24; f++) begin
      prog_mode = ($urandom % 4) == 0;
      odd_first = $urandom % 20; odd_last = $urandom % 24;
      even_first = $urandom % 20; even_last = $urandom % 24;
      frame_first = $urandom % 20; frame_last = $urandom % 24;
      vbi_first = $urandom % 10;
      if (prog_mode) exp_even = 1'b0;
      repeat (2) @(negedge clk);
      vpulse();
      check_all();
      for (int l = 0; l < int'($urandom % 26); l++) begin
        hpulse();
        check_all();
      end
    end

    // R3 saturation
    prog_mode = 1'b0;
    vpulse();
    for (int l = 0; l < 4094; l++) begin
      @(negedge clk) hsync_in = 1'b1;
      repeat (2) @(negedge clk);
      hsync_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    @(negedge clk);
    check(line_num == 4094, "R3 near top", line_num, 4094);
    exp_line = 4094;
    hpulse();
    check(line_num == 4095, "R3 top", line_num, 4095);
    hpulse(); hpulse();
    check(line_num == 4095, "R3 saturate", line_num, 4095);
    vpulse();
    check(line_num == 0, "R2 clear after saturate", line_num, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule